// File: doc/BRIEF.md
# Security-Banked Register Window Filter

This block sits in front of a register file whose registers are banked by security state. It decodes each incoming access against a main register window at the bottom of its address space. When the security extension strap `ext_en` is high, it also decodes a second, 4 KiB alias window placed 0x20000 bytes above the base. The container is 0x21000 bytes long with the extension on and 0x1000 bytes long with it off; with the extension off the alias window does not exist.

Accesses to the main window go to the downstream register port unchanged. In the alias window the attributes decide what happens:
- A secure access is replayed on the downstream port as a non-secure access at the same in-window offset, so the register file selects its non-secure bank.
- A non-secure privileged access is answered locally: a read returns zero and a write is dropped.
- A non-secure unprivileged access gets a bus error.

Any address that lies in neither window also gets a bus error.

The handshake takes one cycle. The downstream port is driven in the same cycle as `req` and answers combinationally. Exactly one response is presented in the cycle after each request. A response state machine makes the response visible, using four states:
- `ST_IDLE`: no response.
- `ST_FWD`: returns the captured downstream data and error status.
- `ST_RAZ`: an OK response with zero data.
- `ST_FAULT`: a bus-error response.

Every state moves on each clock edge. With `req` low the next state is `ST_IDLE`. With `req` high the next state depends on the route decision:
- Pass or demote → `ST_FWD`.
- Local zero → `ST_RAZ`.
- Fault → `ST_FAULT`.

Top module: `alias_window_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `resp_ok`, `resp_err` and `rdata` are all zero.
- R2: An access with address below 0x1000 (main window) drives `dn_req` in the same cycle, with `dn_addr` equal to `addr[11:0]` and `dn_secure` equal to `secure`.
- R3: With `ext_en`=1, a secure access to 0x20000..0x20FFF drives `dn_req` in the same cycle, with `dn_addr` equal to `addr[11:0]` and `dn_secure`=0.
- R4: With `ext_en`=1, a non-secure privileged access (`secure`=0, `user`=0) to the alias window leaves `dn_req` low. In the next cycle it answers `resp_ok`=1 with `rdata`=0. A write has no effect on either register bank.
- R5: With `ext_en`=1, a non-secure unprivileged access (`secure`=0, `user`=1) to the alias window leaves `dn_req` low. In the next cycle it answers `resp_err`=1, and a write has no effect.
- R6: With `ext_en`=0, an access to 0x20000..0x20FFF leaves `dn_req` low and answers `resp_err`=1. The main window still works as in R2.
- R7: An address in neither window, either inside the container gap or beyond the container, leaves `dn_req` low and answers `resp_err`=1.
- R8: A forwarded access returns in the next cycle the `dn_rdata` and `dn_err` seen at the request. `resp_ok` is the inverse of `dn_err`, and `rdata` is 0 for a write.
- R9: Each cycle with `req` high is followed by exactly one of `resp_ok`/`resp_err` in the next cycle. A cycle with `req` low is followed by neither. Back-to-back requests each get their own response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_en | input | 1 | Security extension present (alias window enabled) |
| req | input | 1 | Access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 18 | Byte address relative to container base |
| wdata | input | 32 | Write data |
| secure | input | 1 | Secure attribute of the access |
| user | input | 1 | 1 = unprivileged access |
| rdata | output | 32 | Read data, valid with resp_ok |
| resp_ok | output | 1 | Access completed |
| resp_err | output | 1 | Bus error |
| dn_req | output | 1 | Downstream register-port request |
| dn_we | output | 1 | Downstream write enable |
| dn_addr | output | 12 | In-window offset to register port |
| dn_wdata | output | 32 | Downstream write data |
| dn_secure | output | 1 | Bank-select attribute after rewriting |
| dn_rdata | input | 32 | Downstream read data (combinational) |
| dn_err | input | 1 | Downstream error (combinational) |

## Verification
The bench sweeps every address class with every combination of secure, user and read/write, and with the extension on and off. The address classes are main, alias, container gap, beyond the container, and an alias offset the register file rejects.

- Secure writes through the alias followed by reads of both banks show whether the attribute was really demoted, as opposed to passed through.
- Non-secure alias writes show whether the RAZ/WI and fault paths leak into the register file.
- The rejected offset separates a local fault from a forwarded downstream error.
- Back-to-back requests of differing kinds show whether each response belongs to its own request.

// File: rtl/alias_window_pkg.sv
package alias_window_pkg;

    typedef enum logic [1:0] {
        RT_PASS   = 2'd0,
        RT_DEMOTE = 2'd1,
        RT_RAZ    = 2'd2,
        RT_FAULT  = 2'd3
    } route_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FWD   = 2'd1,
        ST_RAZ   = 2'd2,
        ST_FAULT = 2'd3
    } rsp_state_t;

    typedef struct packed {
        logic in_main;
        logic in_alias;
    } win_hit_t;

endpackage

// File: rtl/aw_decode.sv
module aw_decode
    import alias_window_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int WIN_BITS   = 12,
    parameter int ALIAS_BASE = 32'h20000
) (
    input  logic [ADDR_W-1:0]   addr,
    input  logic                ext_en,
    output win_hit_t            hit,
    output logic [WIN_BITS-1:0] offset
);
    localparam int PAGE_W     = ADDR_W - WIN_BITS;
    localparam int ALIAS_PAGE = ALIAS_BASE >> WIN_BITS;

    logic [PAGE_W-1:0] page;

    always_comb begin
        page         = addr[ADDR_W-1:WIN_BITS];
        offset       = addr[WIN_BITS-1:0];
        hit.in_main  = (page == '0);
        hit.in_alias = ext_en && (page == PAGE_W'(ALIAS_PAGE));
    end
endmodule

// File: rtl/aw_filter.sv
module aw_filter
    import alias_window_pkg::*;
(
    input  win_hit_t hit,
    input  logic     secure,
    input  logic     user,
    output route_t   route,
    output logic     fwd_secure
);
    always_comb begin
        route      = RT_FAULT;
        fwd_secure = 1'b0;
        if (hit.in_main) begin
            route      = RT_PASS;
            fwd_secure = secure;
        end else if (hit.in_alias) begin
            if (secure) begin
                route      = RT_DEMOTE;
                fwd_secure = 1'b0;
            end else if (!user) begin
                route = RT_RAZ;
            end else begin
                route = RT_FAULT;
            end
        end
    end
endmodule

// File: rtl/aw_resp_fsm.sv
module aw_resp_fsm
    import alias_window_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  route_t            route,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic              dn_err,
    output logic [DATA_W-1:0] rdata,
    output logic              resp_ok,
    output logic              resp_err
);
    rsp_state_t        state, state_nx;
    logic [DATA_W-1:0] cap_data;
    logic              cap_err;

    always_comb begin
        state_nx = ST_IDLE;
        if (req) begin
            unique case (route)
                RT_PASS, RT_DEMOTE: state_nx = ST_FWD;
                RT_RAZ:             state_nx = ST_RAZ;
                RT_FAULT:           state_nx = ST_FAULT;
                default:            state_nx = ST_FAULT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cap_data <= '0;
            cap_err  <= 1'b0;
        end else begin
            state <= state_nx;
            if (state_nx == ST_FWD) begin
                cap_data <= we ? '0 : dn_rdata;
                cap_err  <= dn_err;
            end else begin
                cap_data <= '0;
                cap_err  <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata    = '0;
        resp_ok  = 1'b0;
        resp_err = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_FWD: begin
                rdata    = cap_data;
                resp_ok  = !cap_err;
                resp_err = cap_err;
            end
            ST_RAZ:   resp_ok  = 1'b1;
            ST_FAULT: resp_err = 1'b1;
            default:  resp_err = 1'b1;
        endcase
    end
endmodule

// File: rtl/alias_window_filter.sv
module alias_window_filter
    import alias_window_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 32,
    parameter int WIN_BITS   = 12,
    parameter int ALIAS_BASE = 32'h20000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ext_en,
    input  logic                req,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                secure,
    input  logic                user,
    output logic [DATA_W-1:0]   rdata,
    output logic                resp_ok,
    output logic                resp_err,
    output logic                dn_req,
    output logic                dn_we,
    output logic [WIN_BITS-1:0] dn_addr,
    output logic [DATA_W-1:0]   dn_wdata,
    output logic                dn_secure,
    input  logic [DATA_W-1:0]   dn_rdata,
    input  logic                dn_err
);
    win_hit_t            hit;
    logic [WIN_BITS-1:0] offset;
    route_t              route;
    logic                fwd_secure;

    aw_decode #(
        .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .ALIAS_BASE(ALIAS_BASE)
    ) u_decode (
        .addr(addr), .ext_en(ext_en), .hit(hit), .offset(offset)
    );

    aw_filter u_filter (
        .hit(hit), .secure(secure), .user(user),
        .route(route), .fwd_secure(fwd_secure)
    );

    aw_resp_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .route(route),
        .dn_rdata(dn_rdata), .dn_err(dn_err),
        .rdata(rdata), .resp_ok(resp_ok), .resp_err(resp_err)
    );

    always_comb begin
        dn_req    = req && ((route == RT_PASS) || (route == RT_DEMOTE));
        dn_we     = dn_req && we;
        dn_addr   = offset;
        dn_wdata  = wdata;
        dn_secure = dn_req && fwd_secure;
    end
endmodule

// File: rtl/aw_checker.sv
module aw_checker #(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 32,
    parameter int WIN_BITS   = 12,
    parameter int ALIAS_BASE = 32'h20000
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ext_en,
    input logic                req,
    input logic                we,
    input logic [ADDR_W-1:0]   addr,
    input logic                secure,
    input logic                user,
    input logic [DATA_W-1:0]   rdata,
    input logic                resp_ok,
    input logic                resp_err,
    input logic                dn_req,
    input logic [WIN_BITS-1:0] dn_addr,
    input logic                dn_secure,
    input logic [DATA_W-1:0]   dn_rdata,
    input logic                dn_err
);
    localparam int WSZ = 1 << WIN_BITS;

    logic is_main, is_alias;
    always_comb begin
        is_main  = int'(addr) < WSZ;
        is_alias = ext_en && int'(addr) >= ALIAS_BASE && int'(addr) < ALIAS_BASE + WSZ;
    end

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!resp_ok && !resp_err && rdata == '0));

    a_r2_main_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (req && is_main) |-> (dn_req && dn_secure == secure && dn_addr == addr[WIN_BITS-1:0]));

    a_r3_alias_demote: assert property (@(posedge clk) disable iff (!rst_n)
        (req && is_alias && secure) |-> (dn_req && !dn_secure && dn_addr == addr[WIN_BITS-1:0]));

    a_r4_alias_raz: assert property (@(posedge clk) disable iff (!rst_n)
        (req && is_alias && !secure && !user) |-> !dn_req ##1 (resp_ok && rdata == '0));

    a_r5_alias_user_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req && is_alias && !secure && user) |-> !dn_req ##1 resp_err);

    a_r7_miss_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !is_main && !is_alias) |-> !dn_req ##1 resp_err);

    a_r8_fwd_return: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && !we) |=> (rdata == $past(dn_rdata) && resp_err == $past(dn_err)));

    a_r9_one_resp: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> $countones({resp_ok, resp_err}) == 1);

    a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !(resp_ok || resp_err));
endmodule

bind alias_window_filter aw_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BITS(WIN_BITS), .ALIAS_BASE(ALIAS_BASE)
) u_aw_checker (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .req(req), .we(we), .addr(addr),
    .secure(secure), .user(user), .rdata(rdata), .resp_ok(resp_ok),
    .resp_err(resp_err), .dn_req(dn_req), .dn_addr(dn_addr),
    .dn_secure(dn_secure), .dn_rdata(dn_rdata), .dn_err(dn_err)
);

// File: tb/tb_alias_window_filter.sv
`timescale 1ns/1ps
module tb_alias_window_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_en = 1'b1;
    logic        req = 1'b0, we = 1'b0, secure = 1'b0, user = 1'b0;
    logic [17:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, dn_wdata, dn_rdata;
    logic        resp_ok, resp_err, dn_req, dn_we, dn_secure, dn_err;
    logic [11:0] dn_addr;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    alias_window_filter dut (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .req(req), .we(we),
        .addr(addr), .wdata(wdata), .secure(secure), .user(user),
        .rdata(rdata), .resp_ok(resp_ok), .resp_err(resp_err),
        .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata),
        .dn_secure(dn_secure), .dn_rdata(dn_rdata), .dn_err(dn_err)
    );

    // Downstream banked register file model: 16 words per bank, offsets >= 0xF00 reject
    logic [31:0] bank_s [16];
    logic [31:0] bank_n [16];

    always_comb begin
        dn_err   = dn_req && (dn_addr >= 12'hF00);
        dn_rdata = '0;
        if (dn_req && !dn_we)
            dn_rdata = dn_err ? 32'hBAD0_0000 :
                       (dn_secure ? bank_s[dn_addr[5:2]] : bank_n[dn_addr[5:2]]);
    end

    always @(posedge clk)
        if (dn_req && dn_we && !dn_err) begin
            if (dn_secure) bank_s[dn_addr[5:2]] <= dn_wdata;
            else           bank_n[dn_addr[5:2]] <= dn_wdata;
        end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One access; returns same-cycle downstream view and next-cycle response
    task automatic access(input logic w, input logic [17:0] a, input logic [31:0] d,
                          input logic s, input logic u,
                          output logic q, output logic qs, output logic [11:0] qa,
                          output logic [31:0] rd, output logic ok, output logic er);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; secure = s; user = u;
        #1;
        q = dn_req; qs = dn_secure; qa = dn_addr;
        @(negedge clk);
        rd = rdata; ok = resp_ok; er = resp_err;
        req = 1'b0; we = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset ok", {31'd0, resp_ok}, 32'd0);
        check("R1 reset err", {31'd0, resp_err}, 32'd0);
        check("R1 reset rdata", rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset resp", {30'd0, resp_ok, resp_err}, 32'd0);
    endtask

    // Exhaustive sweep against reference model
    task automatic t_sweep();
        logic [17:0] alist [5];
        alist[0] = 18'h00010;   // main, idx 4
        alist[1] = 18'h20014;   // alias, idx 5
        alist[2] = 18'h08000;   // container gap
        alist[3] = 18'h3F000;   // beyond container
        alist[4] = 18'h20F04;   // alias, rejected downstream
        for (int e = 0; e < 2; e++) begin
            ext_en = e[0];
            for (int k = 0; k < 5; k++)
            for (int s = 0; s < 2; s++)
            for (int u = 0; u < 2; u++)
            for (int w = 0; w < 2; w++) begin
                logic q, qs, ok, er, fwd, esec;
                logic [11:0] qa;
                logic [31:0] rd, d, exp_rd, pre_s, pre_n, exp_s, exp_n;
                logic [3:0] idx;
                string tag;
                logic is_main, is_alias;
                is_main  = (alist[k] < 18'h01000);
                is_alias = e[0] && alist[k] >= 18'h20000 && alist[k] < 18'h21000;
                if (is_main)                   tag = "R2";
                else if (is_alias && s[0])     tag = "R3";
                else if (is_alias && !u[0])    tag = "R4";
                else if (is_alias)             tag = "R5";
                else if (!e[0] && alist[k] >= 18'h20000 && alist[k] < 18'h21000) tag = "R6";
                else                           tag = "R7";
                fwd  = is_main || (is_alias && s[0]);
                esec = is_main ? s[0] : 1'b0;
                idx  = alist[k][5:2];
                d    = {8'hC5, 7'd0, e[0], 4'(k), 4'd0, 3'd0, s[0], 3'd0, u[0], 4'(w)};
                pre_s = bank_s[idx]; pre_n = bank_n[idx];
                exp_s = pre_s; exp_n = pre_n;
                exp_rd = 32'd0;
                if (fwd && alist[k][11:0] >= 12'hF00) begin
                    if (!w[0]) exp_rd = 32'hBAD0_0000;
                end else if (fwd) begin
                    if (w[0]) begin
                        if (esec) exp_s = d; else exp_n = d;
                    end else exp_rd = esec ? pre_s : pre_n;
                end
                access(w[0], alist[k], d, s[0], u[0], q, qs, qa, rd, ok, er);
                check({tag, " dn_req"}, {31'd0, q}, {31'd0, fwd});
                if (fwd) begin
                    check({tag, " dn_secure"}, {31'd0, qs}, {31'd0, esec});
                    check({tag, " dn_addr"}, {20'd0, qa}, {20'd0, alist[k][11:0]});
                end
                if (fwd && alist[k][11:0] >= 12'hF00) begin
                    check({tag, " R8 fwd err"}, {30'd0, ok, er}, 32'd1);
                end else if (fwd || tag == "R4") begin
                    check({tag, " ok resp"}, {30'd0, ok, er}, 32'd2);
                end else begin
                    check({tag, " fault resp"}, {30'd0, ok, er}, 32'd1);
                end
                check({tag, " rdata"}, rd, exp_rd);
                check({tag, " bank_s"}, bank_s[idx], exp_s);
                check({tag, " bank_n"}, bank_n[idx], exp_n);
            end
        end
        ext_en = 1'b1;
    endtask

    // Secure alias write lands in NS bank; readable via main NS only
    task automatic t_demote_bank();
        logic q, qs, ok, er;
        logic [11:0] qa;
        logic [31:0] rd;
        access(1'b1, 18'h20020, 32'h1234_5678, 1'b1, 1'b0, q, qs, qa, rd, ok, er);
        access(1'b0, 18'h00020, 32'd0, 1'b0, 1'b0, q, qs, qa, rd, ok, er);
        check("R3 demoted write seen in NS bank", rd, 32'h1234_5678);
        access(1'b0, 18'h00020, 32'd0, 1'b1, 1'b0, q, qs, qa, rd, ok, er);
        check("R2 secure bank untouched", rd, 32'hA000_0008);
        access(1'b0, 18'h20020, 32'd0, 1'b1, 1'b1, q, qs, qa, rd, ok, er);
        check("R3 secure user alias read via NS", rd, 32'h1234_5678);
    endtask

    // Downstream read data passthrough on a forwarded read
    task automatic t_passthrough();
        logic q, qs, ok, er;
        logic [11:0] qa;
        logic [31:0] rd;
        access(1'b0, 18'h00F80, 32'd0, 1'b1, 1'b0, q, qs, qa, rd, ok, er);
        check("R8 err data returned", rd, 32'hBAD0_0000);
        check("R8 err status", {30'd0, ok, er}, 32'd1);
    endtask

    // Back-to-back requests, then idle
    task automatic t_b2b();
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = 18'h0003C; secure = 1'b1; user = 1'b0;
        @(negedge clk);
        check("R9 b2b first data", rdata, 32'hA000_000F);
        check("R9 b2b first ok", {30'd0, resp_ok, resp_err}, 32'd2);
        addr = 18'h20000; secure = 1'b0; user = 1'b1;
        @(negedge clk);
        check("R9 b2b second err", {30'd0, resp_ok, resp_err}, 32'd1);
        addr = 18'h20004; user = 1'b0;
        @(negedge clk);
        check("R9 b2b third raz", {30'd0, resp_ok, resp_err}, 32'd2);
        check("R9 b2b third rdata", rdata, 32'd0);
        req = 1'b0;
        @(negedge clk);
        check("R9 idle no response", {30'd0, resp_ok, resp_err}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            bank_s[i] = 32'hA000_0000 + i;
            bank_n[i] = 32'h5000_0000 + i;
        end
        t_reset();
        t_sweep();
        t_demote_bank();
        t_passthrough();
        t_b2b();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule